// File: doc/BRIEF.md
# Mailbox Command Word Sequencer

This block hands a command packet of 16-bit words to a slave processor through a memory-mapped mailbox. It uses a bus that carries only single-cycle writes. When the start strobe arrives, the block captures the packet. It then issues one write per word, and after every write it waits a programmable number of idle cycles so that the slave has time to react. The header words go out last. The slave sees word 0 land at the mailbox base address, and that write tells it the whole packet is in place.

The packet comes from one of two sources:
- **Raw mode:** the packet is a caller-supplied word array and length.
- **Switch-command mode:** the block builds an 18-word satellite-switch command packet itself, from a command header, a list of message bytes and a tone-burst selector.

A one-cycle done pulse marks the end of the final wait.

Top module: `mbox_seq`

## Requirements
- R1: For a raw packet of length L of at least 3, words L-1 down to 2 are not reordered: indices 2, 3, ..., L-1 are written in ascending order, each to address base + 2*index, before any header word.
- R2: After the body words, one write goes to base + 2. It carries word 1, or the value 0 when L is 0. Lengths 0, 1 and 2 produce exactly two writes.
- R3: The last write of every packet carries word 0 to the base address itself.
- R4: The write strobe is high for one clock per word. Exactly gapCycles idle cycles separate consecutive strobes. A gapCycles of 0 gives back-to-back strobes.
- R5: done is high for exactly one cycle, gapCycles+1 cycles after the last strobe. busy is high from the cycle after start up to and including the done cycle.
- R6: A start strobe seen while busy is ignored. The running packet completes unchanged and no second packet follows.
- R7: In switch-command mode (pktMode=1), word 0 is {cmdType, cmdCode}, with cmdType in bits 15:8.
- R8: In switch-command mode, msgLen is capped at 10. Word 1 is the capped length + 2 and word 2 is the capped length.
- R9: In switch-command mode, burstSel selects word 3 as follows: 2'b11 (burst B) gives 0x0001, 2'b10 (burst A) gives 0x0000, and any value with bit 1 clear (no burst) gives 0xFFFF.
- R10: In switch-command mode, message byte k (msgBytes bits 8k+7:8k) goes zero-extended into word 4+k for k below the capped length. All remaining words up to 17 are zero, and the packet is sent with length 18.
- R11: After reset, busWr, done and busy are all low.
- R12: A raw wordCount above 18 is treated as 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| pktMode | input | 1 | 0: raw word array, 1: build switch-command packet |
| wordsIn | input | 288 | Raw words, word i in bits 16i+15:16i |
| wordCount | input | 5 | Raw packet length in words |
| msgBytes | input | 80 | Message bytes, byte k in bits 8k+7:8k |
| msgLen | input | 4 | Message length in bytes (capped at 10) |
| cmdType | input | 8 | Command type, upper byte of word 0 |
| cmdCode | input | 8 | Send code, lower byte of word 0 |
| burstSel | input | 2 | Bit 1: burst requested, bit 0: burst B |
| gapCycles | input | 8 | Idle cycles after each write, captured at start |
| busAddr | output | 16 | Mailbox write address |
| busData | output | 16 | Mailbox write data |
| busWr | output | 1 | Write strobe |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks the following on every cycle:
- the spacing between strobes, and between the final strobe and done, against the gap setting;
- that done is a single-cycle pulse;
- that the final write of every packet targets the base address;
- that the bus stays quiet while idle.

The write order, the data values, the zero written for an empty packet, the length clamp, the switch-command packet contents and the rejection of a start during a run are only visible through the bench's scenarios. The bench compares each logged write against a list it builds from the requirements.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture packet, select first index
    logic step;  // move to next index in write order
  } seqCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seqState_t;
endpackage

// File: rtl/mbox_seq_dp.sv
module mbox_seq_dp
  import mbox_seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 18,
  parameter int MAX_MSG   = 10,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
  parameter int MLEN_W    = 4,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqCtl_t                     ctl,
  input  logic                        pktMode,
  input  logic [MAX_WORDS*WORD_W-1:0] wordsIn,
  input  logic [LEN_W-1:0]            wordCount,
  input  logic [MAX_MSG*8-1:0]        msgBytes,
  input  logic [MLEN_W-1:0]           msgLen,
  input  logic [7:0]                  cmdType,
  input  logic [7:0]                  cmdCode,
  input  logic [1:0]                  burstSel,
  output logic [ADDR_W-1:0]           busAddr,
  output logic [WORD_W-1:0]           busData,
  output logic                        isLast
);
  logic [WORD_W-1:0] pkt     [MAX_WORDS];
  logic [WORD_W-1:0] dsqWord [MAX_WORDS];
  logic [LEN_W-1:0]  lenReg, newLen, effLen;
  logic [IDX_W-1:0]  idx;
  logic [MLEN_W-1:0] capLen;
  logic [WORD_W-1:0] burstWord;

  assign capLen    = (msgLen > MLEN_W'(MAX_MSG)) ? MLEN_W'(MAX_MSG) : msgLen;
  assign burstWord = burstSel[1] ? (burstSel[0] ? WORD_W'(1) : '0) : '1;
  assign effLen    = (wordCount > LEN_W'(MAX_WORDS)) ? LEN_W'(MAX_WORDS) : wordCount;
  assign newLen    = pktMode ? LEN_W'(MAX_WORDS) : effLen;

  // switch-command packet, one word per position
  for (genvar i = 0; i < MAX_WORDS; i++) begin : gDsq
    if (i == 0) begin : gHead
      assign dsqWord[i] = WORD_W'({cmdType, cmdCode});
    end else if (i == 1) begin : gTot
      assign dsqWord[i] = WORD_W'(capLen) + WORD_W'(2);
    end else if (i == 2) begin : gLen
      assign dsqWord[i] = WORD_W'(capLen);
    end else if (i == 3) begin : gBurst
      assign dsqWord[i] = burstWord;
    end else if (i - 4 < MAX_MSG) begin : gMsg
      assign dsqWord[i] = (MLEN_W'(i - 4) < capLen) ? WORD_W'(msgBytes[(i-4)*8 +: 8]) : '0;
    end else begin : gPad
      assign dsqWord[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      for (int i = 0; i < MAX_WORDS; i++)
        pkt[i] <= pktMode ? dsqWord[i] : wordsIn[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg <= '0;
      idx    <= '0;
    end else if (ctl.load) begin
      lenReg <= newLen;
      idx    <= (newLen > LEN_W'(2)) ? IDX_W'(2) : IDX_W'(1);
    end else if (ctl.step) begin
      if (idx >= IDX_W'(2))
        idx <= (LEN_W'(idx) + LEN_W'(1) < lenReg) ? idx + IDX_W'(1) : IDX_W'(1);
      else
        idx <= '0;
    end
  end

  assign isLast  = (idx == '0);
  assign busAddr = BASE_ADDR + (ADDR_W'(idx) << 1);
  assign busData = (idx == IDX_W'(1) && lenReg == '0) ? '0 : pkt[idx];
endmodule

// File: rtl/mbox_seq_ctl.sv
module mbox_seq_ctl
  import mbox_seq_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             isLast,
  output seqCtl_t          ctl,
  output logic             busWr,
  output logic             busy,
  output logic             done
);
  seqState_t        state;
  logic [GAP_W-1:0] gapReg, cnt;
  logic             adv;

  assign adv = (state == ST_WRITE && gapReg == '0) ||
               (state == ST_WAIT && cnt == GAP_W'(1));

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = adv && !isLast;
    busWr    = (state == ST_WRITE);
    done     = (state == ST_FIN);
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapReg <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          gapReg <= gapCycles;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (gapReg == '0) begin
          state <= isLast ? ST_FIN : ST_WRITE;
        end else begin
          cnt   <= gapReg;
          state <= ST_WAIT;
        end
        ST_WAIT: if (cnt == GAP_W'(1)) begin
          state <= isLast ? ST_FIN : ST_WRITE;
        end else begin
          cnt <= cnt - GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 18,
  parameter int MAX_MSG   = 10,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
  parameter int MLEN_W    = 4,
  parameter int GAP_W     = 8,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        pktMode,
  input  logic [MAX_WORDS*WORD_W-1:0] wordsIn,
  input  logic [LEN_W-1:0]            wordCount,
  input  logic [MAX_MSG*8-1:0]        msgBytes,
  input  logic [MLEN_W-1:0]           msgLen,
  input  logic [7:0]                  cmdType,
  input  logic [7:0]                  cmdCode,
  input  logic [1:0]                  burstSel,
  input  logic [GAP_W-1:0]            gapCycles,
  output logic [ADDR_W-1:0]           busAddr,
  output logic [WORD_W-1:0]           busData,
  output logic                        busWr,
  output logic                        busy,
  output logic                        done
);
  seqCtl_t ctl;
  logic    isLast;

  mbox_seq_ctl #(.GAP_W(GAP_W)) ctlI (
    .clk(clk), .rstN(rstN), .start(start), .gapCycles(gapCycles),
    .isLast(isLast), .ctl(ctl), .busWr(busWr), .busy(busy), .done(done)
  );

  mbox_seq_dp #(
    .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .MAX_MSG(MAX_MSG),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MLEN_W(MLEN_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pktMode(pktMode), .wordsIn(wordsIn),
    .wordCount(wordCount), .msgBytes(msgBytes), .msgLen(msgLen),
    .cmdType(cmdType), .cmdCode(cmdCode), .burstSel(burstSel),
    .busAddr(busAddr), .busData(busData), .isLast(isLast)
  );
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
  parameter int GAP_W  = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input logic              clk,
  input logic              rstN,
  input logic [GAP_W-1:0]  gapCycles,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busy,
  input logic              done
);
  logic              inPkt;
  logic [GAP_W:0]    sinceWr;
  logic [ADDR_W-1:0] lastAddr;
  logic [GAP_W:0]    gapPlus;

  assign gapPlus = (GAP_W+1)'(gapCycles) + (GAP_W+1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt    <= 1'b0;
      sinceWr  <= '0;
      lastAddr <= '0;
    end else begin
      if (busWr) begin
        inPkt    <= 1'b1;
        sinceWr  <= (GAP_W+1)'(1);
        lastAddr <= busAddr;
      end else begin
        if (done) inPkt <= 1'b0;
        if (inPkt) sinceWr <= sinceWr + (GAP_W+1)'(1);
      end
    end
  end

  // R4
  gap_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && inPkt) |-> (sinceWr == gapPlus));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && gapCycles != '0) |=> !busWr);

  // R5
  done_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (inPkt && sinceWr == gapPlus));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  last_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lastAddr == BASE_ADDR));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWr && !done));
endmodule

bind mbox_seq mbox_seq_chk #(.GAP_W(GAP_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chkI (
  .clk(clk), .rstN(rstN), .gapCycles(gapCycles), .busAddr(busAddr),
  .busWr(busWr), .busy(busy), .done(done)
);

// File: tb/tb_mbox_seq.sv
`timescale 1ns/1ps
module tb_mbox_seq;
  localparam int NW = 18;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, pktMode = 1'b0;
  logic [NW*16-1:0] wordsIn = '0;
  logic [4:0]  wordCount = '0;
  logic [79:0] msgBytes = '0;
  logic [3:0]  msgLen = '0;
  logic [7:0]  cmdType = '0, cmdCode = '0;
  logic [1:0]  burstSel = '0;
  logic [7:0]  gapCycles = '0;
  logic [15:0] busAddr, busData;
  logic busWr, busy, done;

  mbox_seq dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // write log, sampled away from the active edge
  int logN = 0, doneCnt = 0, doneCyc = 0;
  logic [15:0] logA [40];
  logic [15:0] logD [40];
  int wrCyc [40];
  always @(negedge clk) begin
    if (busWr && logN < 40) begin
      logA[logN] = busAddr; logD[logN] = busData; wrCyc[logN] = cyc; logN = logN + 1;
    end
    if (done) begin doneCnt = doneCnt + 1; doneCyc = cyc; end
  end

  // expected packet built by the bench
  logic [15:0] pw [NW];
  logic [15:0] expA [40];
  logic [15:0] expD [40];
  int expN;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic buildExp(input int len);
    expN = 0;
    for (int i = 2; i < len; i++) begin
      expA[expN] = BASE + 16'(2*i); expD[expN] = pw[i]; expN++;
    end
    expA[expN] = BASE + 16'd2; expD[expN] = (len == 0) ? 16'h0 : pw[1]; expN++;
    expA[expN] = BASE;         expD[expN] = pw[0];                    expN++;
  endtask

  task automatic runPkt(input string tag, input int gap, input bit extraStart);
    int startCyc, w;
    @(negedge clk);
    logN = 0; doneCnt = 0;
    gapCycles = 8'(gap);
    start = 1'b1; startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (extraStart) begin
      repeat (3) @(negedge clk);
      wordsIn = ~wordsIn; wordCount = 5'd7; pktMode = ~pktMode;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (doneCnt == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (gap + 6) @(negedge clk);
    chk(logN == expN, {tag, " write count"}, logN, expN);
    for (int k = 0; k < expN && k < logN; k++) begin
      chk(logA[k] == expA[k], {tag, " address"}, logA[k], expA[k]);
      chk(logD[k] == expD[k], {tag, " data"}, logD[k], expD[k]);
    end
    if (logN > 0) begin
      // R4 first strobe one cycle after start, then spacing gap+1
      chk(wrCyc[0] == startCyc + 1, "R4 first strobe", wrCyc[0], startCyc + 1);
      for (int k = 1; k < logN; k++)
        chk(wrCyc[k] - wrCyc[k-1] == gap + 1, "R4 spacing", wrCyc[k] - wrCyc[k-1], gap + 1);
      // R5 done timing and single pulse
      chk(doneCyc - wrCyc[logN-1] == gap + 1, "R5 done delay", doneCyc - wrCyc[logN-1], gap + 1);
    end
    chk(doneCnt == 1, "R5 done count", doneCnt, 1);
    chk(busy == 1'b0, "R5 busy after done", busy, 0);
  endtask

  task automatic tReset;
    chk(busWr == 1'b0, "R11 busWr", busWr, 0);
    chk(done == 1'b0,  "R11 done",  done, 0);
    chk(busy == 1'b0,  "R11 busy",  busy, 0);
  endtask

  task automatic tRaw(input string tag, input int len, input int gap, input logic [15:0] seed);
    int effL;
    for (int i = 0; i < NW; i++) begin
      pw[i] = seed ^ 16'(i * 16'h1111) ^ 16'(i);
      wordsIn[i*16 +: 16] = pw[i];
    end
    pktMode = 1'b0; wordCount = 5'(len);
    effL = (len > NW) ? NW : len; // R12 clamp
    buildExp(effL);
    runPkt(tag, gap, 1'b0);
  endtask

  task automatic tDsq(input string tag, input int len, input logic [1:0] bsel, input int gap);
    int capL;
    capL = (len > 10) ? 10 : len;
    cmdType = 8'h3C; cmdCode = 8'h5A;
    for (int k = 0; k < 10; k++) msgBytes[k*8 +: 8] = 8'hA1 + 8'(k*7);
    pktMode = 1'b1; msgLen = 4'(len); burstSel = bsel;
    wordsIn = '1; wordCount = 5'd3;
    pw[0] = {cmdType, cmdCode};
    pw[1] = 16'(capL + 2);
    pw[2] = 16'(capL);
    pw[3] = bsel[1] ? (bsel[0] ? 16'h0001 : 16'h0000) : 16'hFFFF;
    for (int i = 4; i < NW; i++)
      pw[i] = (i - 4 < capL) ? {8'h00, msgBytes[(i-4)*8 +: 8]} : 16'h0000;
    buildExp(NW);
    runPkt(tag, gap, 1'b0);
  endtask

  task automatic tBusyStart;
    for (int i = 0; i < NW; i++) begin
      pw[i] = 16'hC000 + 16'(i);
      wordsIn[i*16 +: 16] = pw[i];
    end
    pktMode = 1'b0; wordCount = 5'd4;
    buildExp(4);
    runPkt("R6 start while busy", 5, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tRaw("R1 R3 raw len 5", 5, 3, 16'h1234);
    tRaw("R2 raw len 0", 0, 2, 16'h4321);
    tRaw("R2 raw len 1", 1, 0, 16'h0F0F);
    tRaw("R2 raw len 2", 2, 1, 16'h9999);
    tRaw("R1 raw len 18", 18, 0, 16'h7E01);
    tRaw("R12 raw len clamp", 25, 1, 16'h2468);
    tDsq("R7 R8 R9 R10 no burst", 3, 2'b00, 1);
    tDsq("R8 R9 capped burst B", 14, 2'b11, 2);
    tDsq("R9 R10 empty burst A", 0, 2'b10, 0);
    tBusyStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule